// File: doc/BRIEF.md
# Offset-Compensated Histogram Builder

This block builds a timing histogram for one time-interval converter channel. Measurement results arrive as a serial stream of 20-bit words. The block reassembles each word in the local clock domain and subtracts a programmable offset. The offset places the time origin of the histogram and removes the fixed path skew of the channel. The difference is then divided by 1, 2, 4 or 8 with a right shift, which sets the bin width. If the result lands inside the window of `2^BIN_AW` bins, the count in that bin is incremented by a read-modify-write pipeline. Results that fall outside the window are discarded and counted.

A second input carries already-summed multi-channel words when the system averages several converters. In that mode the upper one to three bits of the word choose which channel's histogram receives the event, and the lower `BIN_AW` bits give the bin. A host port reads single bins and adds an incoming partial sum to each one, so several channels can be merged bin by bin into one interleaved histogram. A clear command zeroes every bin in turn.

Top module: `histo_builder`

## Requirements
- R1: Serial words are `RES_W` bits long and arrive most significant bit first. A bit with `ser_sof` high always starts a new word, even if an earlier word is incomplete. The word is complete when its last bit has been clocked in. Bits received with no word in progress are ignored.
- R2: In serial mode the bin index is `(result - offset) >> bin_scale`, where `bin_scale` values 0, 1, 2 and 3 give shifts of 0, 1, 2 and 3 bits.
- R3: A result smaller than the offset is not binned, and it raises `oor_count` by one.
- R4: A shifted difference of `2^BIN_AW` or more is not binned, and it raises `oor_count` by one. `oor_count` saturates at its maximum value.
- R5: Each accepted event raises the count of its bin by exactly one.
- R6: A bin count stops at `2^CNT_W - 1` and never wraps.
- R7: Events on consecutive cycles, whether to the same bin or to alternating bins, lose no increment.
- R8: When `avg_mode` is 1, the event source is `avg_vld`/`avg_word`. Bits `[BIN_AW+2:BIN_AW]` are masked to their low `avg_span` bits (span 1, 2 or 3). The event is accepted only when the masked value equals the masked `CHAN_ID`, and its bin is `avg_word[BIN_AW-1:0]`. In this mode serial words are ignored and do not change `oor_count`.
- R9: When `rd_en` is sampled high, `rd_valid` is high one cycle later, and `rd_data` then equals the count of bin `rd_addr` plus `rd_sum_in`.
- R10: A `clr_start` pulse holds `clr_busy` high for exactly `2^BIN_AW` cycles, during which every bin is zeroed. `clr_done` pulses for one cycle as `clr_busy` falls. Events that arrive while `clr_busy` is high leave no trace.
- R11: After reset, `oor_count` is 0 and `clr_busy`, `clr_done` and `rd_valid` are low. Bin contents are undefined until the first clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial bit strobe |
| ser_sof | input | 1 | Marks the first bit of a word |
| ser_bit | input | 1 | Serial data bit |
| offset | input | RES_W | Value subtracted from each result |
| bin_scale | input | 2 | Right shift amount (0 to 3) |
| avg_mode | input | 1 | Selects the pre-summed input as the event source |
| avg_vld | input | 1 | Pre-summed word strobe |
| avg_word | input | BIN_AW+3 | Pre-summed word: channel select bits above the bin |
| avg_span | input | 2 | Number of channel select bits (1 to 3) |
| clr_start | input | 1 | Starts a clear sweep |
| clr_busy | output | 1 | Clear sweep in progress |
| clr_done | output | 1 | One-cycle pulse when the sweep ends |
| rd_en | input | 1 | Host read request |
| rd_addr | input | BIN_AW | Bin to read |
| rd_sum_in | input | SUM_W | Partial sum added to the bin |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | SUM_W | Bin count plus partial sum |
| oor_count | output | OOR_W | Saturating count of out-of-window results |

## Verification
The assertions assume three things. `clr_start` is pulsed only while no sweep is running. `avg_span` is not zero while averaged events are sent. `rd_sum_in` plus a bin count fits in `SUM_W` bits. The stimulus keeps to all three: it issues one clear at a time and waits for `clr_done`, and it uses spans of 1, 2 and 3 only. It reads with sums small enough that the addition cannot overflow. The bench also clears the memory before it reads any bin, because bin contents are undefined after reset.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      SCALE_1 = 2'd0,
      SCALE_2 = 2'd1,
      SCALE_4 = 2'd2,
      SCALE_8 = 2'd3
   } bin_scale_e;

   localparam int SEL_W = 3;
endpackage

// File: rtl/hb_deser.sv
module hb_deser #(
   parameter int RES_W     = 20,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_en,
   input  logic             ser_sof,
   input  logic             ser_bit,
   output logic             word_vld,
   output logic [RES_W-1:0] word
);
   localparam int CW = $clog2(RES_W + 1);

   logic [RES_W-1:0] sh, sh_nx;
   logic [CW-1:0]    cnt, cur;

   if (RES_W < 2) begin : g_chk_w
      $error("hb_deser: RES_W must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      assign sh_nx = {sh[RES_W-2:0], ser_bit};
   end else begin : g_lsb
      assign sh_nx = {ser_bit, sh[RES_W-1:1]};
   end

   assign cur = ser_sof ? CW'(1) : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sh       <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (ser_en) begin
            sh <= sh_nx;
            if (ser_sof || cnt != '0) begin
               if (cur == CW'(RES_W)) begin
                  word_vld <= 1'b1;
                  word     <= sh_nx;
                  cnt      <= '0;
               end else begin
                  cnt <= cur;
               end
            end
         end
      end
   end

   // R1: a finished word always follows a received bit
   a_r1_word_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(ser_en));
endmodule

// File: rtl/hb_bin_map.sv
module hb_bin_map
   import hb_pkg::*;
#(
   parameter int RES_W   = 20,
   parameter int BIN_AW  = 10,
   parameter int CHAN_ID = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    avg_mode,
   input  logic                    des_vld,
   input  logic [RES_W-1:0]        des_word,
   input  logic [RES_W-1:0]        offset,
   input  logic [1:0]              bin_scale,
   input  logic                    avg_vld,
   input  logic [BIN_AW+SEL_W-1:0] avg_word,
   input  logic [1:0]              avg_span,
   output logic                    evt_vld,
   output logic [BIN_AW-1:0]       evt_addr,
   output logic                    oor_pulse
);
   localparam logic [SEL_W-1:0] ID = SEL_W'(CHAN_ID);

   if (RES_W <= BIN_AW) begin : g_chk_win
      $error("hb_bin_map: RES_W must exceed BIN_AW");
   end
   if (CHAN_ID < 0 || CHAN_ID >= (1 << SEL_W)) begin : g_chk_id
      $error("hb_bin_map: CHAN_ID out of range");
   end

   logic [RES_W:0]     diff;
   logic [RES_W-1:0]   mag;
   logic               neg, high, ser_hit, avg_hit;
   logic [SEL_W-1:0]   mask;
   bin_scale_e         scale;

   assign scale = bin_scale_e'(bin_scale);
   assign diff  = {1'b0, des_word} - {1'b0, offset};
   assign neg   = diff[RES_W];

   always_comb begin
      unique case (scale)
         SCALE_1: mag = diff[RES_W-1:0];
         SCALE_2: mag = diff[RES_W-1:0] >> 1;
         SCALE_4: mag = diff[RES_W-1:0] >> 2;
         default: mag = diff[RES_W-1:0] >> 3;
      endcase
      unique case (avg_span)
         2'd0:    mask = 3'b000;
         2'd1:    mask = 3'b001;
         2'd2:    mask = 3'b011;
         default: mask = 3'b111;
      endcase
   end

   assign high    = |mag[RES_W-1:BIN_AW];
   assign ser_hit = des_vld && !neg && !high;
   assign avg_hit = avg_vld && ((avg_word[BIN_AW +: SEL_W] & mask) == (ID & mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_vld   <= 1'b0;
         evt_addr  <= '0;
         oor_pulse <= 1'b0;
      end else begin
         evt_vld   <= !hold && (avg_mode ? avg_hit : ser_hit);
         evt_addr  <= avg_mode ? avg_word[BIN_AW-1:0] : mag[BIN_AW-1:0];
         oor_pulse <= !hold && !avg_mode && des_vld && (neg || high);
      end
   end

   // R3 / R4: a dropped result is never also binned
   a_r3_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      oor_pulse |-> !evt_vld);
   // R2: serial events only follow a finished word
   a_r2_evt_src: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && !$past(avg_mode)) |-> $past(des_vld));
endmodule

// File: rtl/hb_rmw_mem.sv
module hb_rmw_mem #(
   parameter int BIN_AW = 10,
   parameter int CNT_W  = 18,
   parameter int SUM_W  = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_vld,
   input  logic [BIN_AW-1:0] evt_addr,
   input  logic              clr_start,
   input  logic              rd_en,
   input  logic [BIN_AW-1:0] rd_addr,
   input  logic [SUM_W-1:0]  rd_sum_in,
   output logic              clr_busy,
   output logic              clr_done,
   output logic              rd_valid,
   output logic [SUM_W-1:0]  rd_data
);
   localparam int DEPTH = 1 << BIN_AW;
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   if (SUM_W < CNT_W) begin : g_chk_sum
      $error("hb_rmw_mem: SUM_W must be at least CNT_W");
   end

   logic [CNT_W-1:0]  mem [DEPTH];
   logic              b_vld, lw_vld, wr_en;
   logic [BIN_AW-1:0] b_addr, lw_addr, wr_addr, clr_ptr;
   logic [CNT_W-1:0]  b_q, lw_val, base, inc, wr_val, host_q;
   logic [SUM_W-1:0]  sum_q;

   assign base    = (lw_vld && lw_addr == b_addr) ? lw_val : b_q;
   assign inc     = (base == CMAX) ? base : base + 1'b1;
   assign wr_en   = clr_busy || b_vld;
   assign wr_addr = clr_busy ? clr_ptr : b_addr;
   assign wr_val  = clr_busy ? '0 : inc;
   assign rd_data = SUM_W'(host_q) + sum_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_val;
      b_q    <= mem[evt_addr];
      host_q <= (wr_en && wr_addr == rd_addr) ? wr_val : mem[rd_addr];
      sum_q  <= rd_sum_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_vld    <= 1'b0;
         b_addr   <= '0;
         lw_vld   <= 1'b0;
         lw_addr  <= '0;
         lw_val   <= '0;
         clr_busy <= 1'b0;
         clr_done <= 1'b0;
         clr_ptr  <= '0;
         rd_valid <= 1'b0;
      end else begin
         b_vld    <= evt_vld && !clr_busy;
         b_addr   <= evt_addr;
         lw_vld   <= b_vld && !clr_busy;
         lw_addr  <= b_addr;
         lw_val   <= inc;
         rd_valid <= rd_en;
         clr_done <= 1'b0;
         if (clr_busy) begin
            clr_ptr <= clr_ptr + 1'b1;
            if (clr_ptr == {BIN_AW{1'b1}}) begin
               clr_busy <= 1'b0;
               clr_done <= 1'b1;
            end
         end else if (clr_start) begin
            clr_busy <= 1'b1;
            clr_ptr  <= '0;
         end
      end
   end

   // R6: an increment never writes zero, so counts cannot wrap
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && !clr_busy) |-> wr_val != '0);
   // R7: back-to-back hits on one bin build on each other
   a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && !clr_busy && $past(b_vld && !clr_busy) && b_addr == $past(b_addr))
      |-> (wr_val == $past(wr_val) + 1'b1) || (wr_val == CMAX && $past(wr_val) == CMAX));
   // R9: read data follows a request after one cycle
   a_r9_rd_lat: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   // R10: the sweep walks the bins in order and ends with a done pulse
   a_r10_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy && $past(clr_busy)) |-> clr_ptr == $past(clr_ptr) + 1'b1);
   a_r10_done: assert property (@(posedge clk) disable iff (!rst_n)
      clr_done |-> ($past(clr_busy) && !clr_busy));
endmodule

// File: rtl/histo_builder.sv
module histo_builder
   import hb_pkg::*;
#(
   parameter int RES_W     = 20,
   parameter int BIN_AW    = 10,
   parameter int CNT_W     = 18,
   parameter int SUM_W     = 21,
   parameter int OOR_W     = 16,
   parameter int CHAN_ID   = 0,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_en,
   input  logic                    ser_sof,
   input  logic                    ser_bit,
   input  logic [RES_W-1:0]        offset,
   input  logic [1:0]              bin_scale,
   input  logic                    avg_mode,
   input  logic                    avg_vld,
   input  logic [BIN_AW+2:0]       avg_word,
   input  logic [1:0]              avg_span,
   input  logic                    clr_start,
   output logic                    clr_busy,
   output logic                    clr_done,
   input  logic                    rd_en,
   input  logic [BIN_AW-1:0]       rd_addr,
   input  logic [SUM_W-1:0]        rd_sum_in,
   output logic                    rd_valid,
   output logic [SUM_W-1:0]        rd_data,
   output logic [OOR_W-1:0]        oor_count
);
   if (SEL_W != 3) begin : g_chk_sel
      $error("histo_builder: avg_word layout assumes three select bits");
   end

   logic              des_vld, evt_vld, oor_pulse;
   logic [RES_W-1:0]  des_word;
   logic [BIN_AW-1:0] evt_addr;

   hb_deser #(.RES_W(RES_W), .MSB_FIRST(MSB_FIRST)) u_deser (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_sof(ser_sof),
      .ser_bit(ser_bit), .word_vld(des_vld), .word(des_word));

   hb_bin_map #(.RES_W(RES_W), .BIN_AW(BIN_AW), .CHAN_ID(CHAN_ID)) u_map (
      .clk(clk), .rst_n(rst_n), .hold(clr_busy), .avg_mode(avg_mode),
      .des_vld(des_vld), .des_word(des_word), .offset(offset),
      .bin_scale(bin_scale), .avg_vld(avg_vld), .avg_word(avg_word),
      .avg_span(avg_span), .evt_vld(evt_vld), .evt_addr(evt_addr),
      .oor_pulse(oor_pulse));

   hb_rmw_mem #(.BIN_AW(BIN_AW), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_addr(evt_addr),
      .clr_start(clr_start), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_sum_in(rd_sum_in), .clr_busy(clr_busy), .clr_done(clr_done),
      .rd_valid(rd_valid), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             oor_count <= '0;
      else if (oor_pulse && oor_count != '1)  oor_count <= oor_count + 1'b1;
   end

   // R4: the drop counter only ever steps by one
   a_r4_oor_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oor_count) |-> oor_count == $past(oor_count) + 1'b1);
   // R8: serial traffic cannot move the drop counter in averaging mode
   a_r8_avg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_mode && $past(avg_mode) && $past(avg_mode, 2)) |-> $stable(oor_count));
endmodule

// File: tb/histo_builder_tb.sv
module histo_builder_tb_top;
   localparam int RW = 20, AW = 8, CW = 5, SW = 12, OW = 8, ID = 1;
   localparam int NV = 15;
   // {result, offset, scale}
   localparam logic [41:0] VEC [NV] = '{
      {20'd100,    20'd0,      2'd0}, {20'd100,  20'd40,  2'd0},
      {20'd1000,   20'd200,    2'd2}, {20'd1000, 20'd0,   2'd2},
      {20'd50,     20'd60,     2'd0}, {20'd256,  20'd0,   2'd0},
      {20'd255,    20'd0,      2'd0}, {20'd2047, 20'd0,   2'd3},
      {20'd2048,   20'd0,      2'd3}, {20'hFFFFF, 20'hFFF00, 2'd0},
      {20'd0,      20'd0,      2'd1}, {20'd61,   20'd60,  2'd1},
      {20'd0,      20'd1,      2'd0}, {20'd520,  20'd10,  2'd1},
      {20'd4100,   20'd4000,   2'd3}};
   // expected bin, -1 means dropped
   localparam int VBIN [NV] = '{100, 60, 200, 250, -1, -1, 255, 255, -1, 255,
                                0, 0, -1, 255, 12};

   logic clk = 0, rst_n = 0;
   logic ser_en = 0, ser_sof = 0, ser_bit = 0;
   logic [RW-1:0] offset = '0;
   logic [1:0] bin_scale = '0, avg_span = 2'd1;
   logic avg_mode = 0, avg_vld = 0, clr_start = 0, rd_en = 0;
   logic [AW+2:0] avg_word = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [SW-1:0] rd_sum_in = '0;
   logic clr_busy, clr_done, rd_valid;
   logic [SW-1:0] rd_data;
   logic [OW-1:0] oor_count;

   int checks = 0, errors = 0;
   int model [256];

   always #4 clk = ~clk;

   histo_builder #(.RES_W(RW), .BIN_AW(AW), .CNT_W(CW), .SUM_W(SW),
                   .OOR_W(OW), .CHAN_ID(ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_sof(ser_sof),
      .ser_bit(ser_bit), .offset(offset), .bin_scale(bin_scale),
      .avg_mode(avg_mode), .avg_vld(avg_vld), .avg_word(avg_word),
      .avg_span(avg_span), .clr_start(clr_start), .clr_busy(clr_busy),
      .clr_done(clr_done), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_sum_in(rd_sum_in), .rd_valid(rd_valid), .rd_data(rd_data),
      .oor_count(oor_count));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [RW-1:0] w, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         ser_en = 1; ser_sof = (i == 0); ser_bit = w[RW-1-i];
      end
      @(negedge clk);
      ser_en = 0; ser_sof = 0;
   endtask

   task automatic send_word(input logic [RW-1:0] w);
      send_bits(w, RW);
      idle(6);
   endtask

   task automatic avg_send(input logic [AW+2:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         avg_vld = 1; avg_word = w;
      end
      @(negedge clk);
      avg_vld = 0;
      idle(5);
   endtask

   task automatic read_bin(input int a, input int s, output int val, output int vld);
      @(negedge clk);
      rd_en = 1; rd_addr = AW'(a); rd_sum_in = SW'(s);
      @(negedge clk);
      rd_en = 0;
      val = int'(rd_data); vld = int'(rd_valid);
   endtask

   task automatic do_clear(output int busy_cycles);
      busy_cycles = 0;
      @(negedge clk);
      clr_start = 1;
      @(negedge clk);
      clr_start = 0;
      for (int i = 0; i < 2000 && !clr_done; i++) begin
         if (clr_busy) busy_cycles++;
         @(negedge clk);
      end
      for (int i = 0; i < 256; i++) model[i] = 0;
      idle(2);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v, vl, bc, oor_exp, nz;
      idle(3);
      // R11: reset values
      check("R11 oor_count", int'(oor_count), 0);
      check("R11 clr_busy", int'(clr_busy), 0);
      check("R11 rd_valid", int'(rd_valid), 0);
      rst_n = 1;
      idle(2);

      // R10: clear sweep length, then memory reads zero
      do_clear(bc);
      check("R10 busy cycles", bc, 256);
      read_bin(0, 0, v, vl);   check("R10 bin0 zero", v, 0);
      read_bin(255, 0, v, vl); check("R10 bin255 zero", v, 0);

      // R2/R3/R4/R5: table walk
      oor_exp = 0;
      for (int k = 0; k < NV; k++) begin
         offset = VEC[k][21:2]; bin_scale = VEC[k][1:0];
         send_word(VEC[k][41:22]);
         if (VBIN[k] < 0) begin
            oor_exp++;
            check("R3/R4 dropped result counted", int'(oor_count), oor_exp);
         end else begin
            model[VBIN[k]]++;
            read_bin(VBIN[k], 0, v, vl);
            check("R2/R5 bin count", v, model[VBIN[k]]);
            check("R3/R4 in-window not counted", int'(oor_count), oor_exp);
         end
      end

      // R9: read adds partial sum, valid after one cycle
      read_bin(100, 1000, v, vl);
      check("R9 rd_data sum", v, model[100] + 1000);
      check("R9 rd_valid", vl, 1);
      idle(1);
      check("R9 rd_valid low when idle", int'(rd_valid), 0);

      // R1: an incomplete word is abandoned at a new start bit
      offset = '0; bin_scale = 2'd0;
      send_bits(20'hFFFFF, 7);
      send_word(20'd30);
      model[30]++;
      read_bin(30, 0, v, vl);
      check("R1 restart on sof", v, model[30]);
      check("R1 partial word not binned", int'(oor_count), oor_exp);

      // R8: averaging input, channel select masking
      avg_mode = 1; avg_span = 2'd2;
      avg_send({3'b001, 8'd7}, 1);
      avg_send({3'b101, 8'd7}, 1);
      avg_send({3'b010, 8'd7}, 1);
      avg_span = 2'd1;
      avg_send({3'b011, 8'd7}, 1);
      avg_send({3'b110, 8'd7}, 1);
      avg_span = 2'd3;
      avg_send({3'b001, 8'd9}, 1);
      avg_send({3'b101, 8'd9}, 1);
      model[7] += 3; model[9] += 1;
      read_bin(7, 0, v, vl); check("R8 bin7 selected events", v, model[7]);
      read_bin(9, 0, v, vl); check("R8 bin9 full mask", v, model[9]);
      send_word(20'd7);
      send_word(20'd5000);
      read_bin(7, 0, v, vl); check("R8 serial ignored bin", v, model[7]);
      check("R8 serial ignored oor", int'(oor_count), oor_exp);

      // R7: back-to-back and alternating events
      avg_send({3'b001, 8'd20}, 6);
      model[20] += 6;
      read_bin(20, 0, v, vl); check("R7 back-to-back same bin", v, model[20]);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         avg_vld = 1; avg_word = {3'b001, ((i % 2) == 0) ? 8'd21 : 8'd22};
      end
      @(negedge clk); avg_vld = 0; idle(5);
      read_bin(21, 0, v, vl); check("R7 alternating bin21", v, 2);
      read_bin(22, 0, v, vl); check("R7 alternating bin22", v, 2);

      // R6: saturation at 2^CW - 1
      avg_send({3'b001, 8'd40}, 40);
      read_bin(40, 0, v, vl); check("R6 saturated count", v, 31);
      avg_send({3'b001, 8'd40}, 2);
      read_bin(40, 0, v, vl); check("R6 stays saturated", v, 31);

      // R10: events during the sweep are ignored
      @(negedge clk); clr_start = 1;
      @(negedge clk); clr_start = 0;
      idle(10);
      avg_send({3'b001, 8'd5}, 20);
      for (int i = 0; i < 2000 && !clr_done; i++) @(negedge clk);
      for (int i = 0; i < 256; i++) model[i] = 0;
      idle(3);
      read_bin(5, 0, v, vl); check("R10 event during clear ignored", v, 0);
      nz = 0;
      for (int a = 0; a < 256; a++) begin
         read_bin(a, 0, v, vl);
         if (v != 0) nz++;
      end
      check("R10 all bins zero after clear", nz, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule